// File: doc/BRIEF.md
# Paged Register Access Front-End for a Word-Framed Serial Slave

This block sits behind a serial slave that has already gathered whole 16-bit words. It turns a two-word exchange into one access to a paged register space. The first word is a command. It carries a direction bit, a page number and a register offset. The second word finishes the access: it is either the data to write or a slot in which read data travels back. The block drives simple register-bank strobes (page, offset, write enable, write data, read enable) and takes the read data back. It also keeps sticky flags for protocol misuse.

Reads advance the offset by one, so a host can stream consecutive registers by sending zero words. One control register acts as a reset key. Writing the key value to it clears the block's own state and pulses a reset output for the register bank. Any other value written to that register has no effect.

Top module: `spi_page_front`

## Requirements
- R1: A word whose reported length (`word_len`) is not 16 is rejected. It causes no strobe and no change to the command state. The cycle after it, `word_out` is 0.
- R2: When no access is pending, a nonzero word is a command. Bit 15 set means read and clear means write. Bits 14:11 are the page and bits 10:5 are the offset. A command raises no strobe and sets `word_out` to 0.
- R3: The word after a write command is written, even when it is zero. One cycle after that word, `reg_wr` pulses for one cycle with the command's page and offset and with `reg_wdata` equal to the word. The block then waits for a new command.
- R4: The word after a read command triggers a read. One cycle after that word, `reg_rd` pulses with the current page and offset. The cycle after the pulse, `word_out` holds the `reg_rdata` that was presented during the pulse.
- R5: Every read advances the stored offset by one, and the offset wraps from 63 to 0. A write does not advance the offset.
- R6: A zero word with no access pending is a read at the stored page and offset. It sets the sticky `underrun` flag if the last decoded command was a write.
- R7: A nonzero word that arrives while a read is pending completes that read at the old address. The same word is then decoded as the next command, and the sticky `overrun` flag is set.
- R8: Only pages 0, 1 and 2 exist. An access to pages 3 to 15 raises no strobe and sets the sticky `page_err` flag. A read of such a page makes `word_out` 16'hFFFF in the cycle after the word.
- R9: Writing 16'hBB00 to page 1, offset 4 raises no `reg_wr`. Instead, `soft_reset` pulses in the next cycle, all flags clear, and the stored page, offset and last-command direction all return to zero. Any other value written to page 1, offset 4 raises no strobe and changes nothing.
- R10: `overrun`, `underrun` and `page_err` stay set until a hard reset or a key write.
- R11: After a hard reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | One-cycle pulse: a whole serial word has arrived |
| word_in | input | 16 | Received word |
| word_len | input | 5 | Bit count of the received transfer |
| word_out | output | 16 | Word to return on the next transfer |
| reg_page | output | 4 | Page of the current strobe |
| reg_offset | output | 6 | Register offset of the current strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 16 | Read data, valid while `reg_rd` is high |
| soft_reset | output | 1 | One-cycle pulse after a key write |
| overrun | output | 1 | Sticky: a command arrived while a read was pending |
| underrun | output | 1 | Sticky: a read was made without a read command |
| page_err | output | 1 | Sticky: an access addressed a page that does not exist |

## Verification
The assertions assume that `word_valid` is a single-cycle pulse and that at least two idle cycles separate words. This keeps a read-data capture from colliding with the handling of the next word. They also assume that the register bank presents `reg_rdata` in the same cycle as `reg_rd`. The bench derives `reg_rdata` combinationally from the page and offset strobes, so every return value is predictable. It sends each word and then waits three cycles before sending the next, which keeps every scenario within those assumptions.

// File: rtl/spi_page_front.sv
module spi_page_front #(
  parameter int WORD_W    = 16,
  parameter int PAGE_W    = 4,
  parameter int OFF_W     = 6,
  parameter int NUM_PAGES = 3,
  parameter int CTRL_PAGE = 1,
  parameter int KEY_REG   = 4,
  parameter logic [15:0] KEY_VAL = 16'hBB00
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         word_valid,
  input  logic [WORD_W-1:0]            word_in,
  input  logic [$clog2(WORD_W+1)-1:0]  word_len,
  output logic [WORD_W-1:0]            word_out,
  output logic [PAGE_W-1:0]            reg_page,
  output logic [OFF_W-1:0]             reg_offset,
  output logic                         reg_wr,
  output logic [WORD_W-1:0]            reg_wdata,
  output logic                         reg_rd,
  input  logic [WORD_W-1:0]            reg_rdata,
  output logic                         soft_reset,
  output logic                         overrun,
  output logic                         underrun,
  output logic                         page_err
);
  localparam int LEN_W   = $clog2(WORD_W+1);
  localparam int DIR_BIT = WORD_W - 1;
  localparam int PG_TOP  = WORD_W - 2;
  localparam int OFF_TOP = PG_TOP - PAGE_W;

  logic              pend_q, cmdrd_q;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  logic acc, zero_w, page_ok, do_rd, do_wr, do_cmd, key_reg, key_hit;

  assign acc     = word_valid && (word_len == LEN_W'(WORD_W));
  assign zero_w  = (word_in == '0);
  assign page_ok = (page_q < PAGE_W'(NUM_PAGES));
  assign do_rd   = acc && ((pend_q && cmdrd_q) || (!pend_q && zero_w));
  assign do_wr   = acc && pend_q && !cmdrd_q;
  assign do_cmd  = acc && !zero_w && !do_wr;
  assign key_reg = do_wr && (page_q == PAGE_W'(CTRL_PAGE)) && (off_q == OFF_W'(KEY_REG));
  assign key_hit = key_reg && (word_in == WORD_W'(KEY_VAL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0; cmdrd_q <= 1'b0; page_q <= '0; off_q <= '0;
      word_out <= '0; reg_page <= '0; reg_offset <= '0; reg_wdata <= '0;
      reg_wr <= 1'b0; reg_rd <= 1'b0; soft_reset <= 1'b0;
      overrun <= 1'b0; underrun <= 1'b0; page_err <= 1'b0;
    end else begin
      reg_wr     <= 1'b0;
      reg_rd     <= 1'b0;
      soft_reset <= 1'b0;
      if (reg_rd) word_out <= reg_rdata;
      if (key_hit) begin
        pend_q <= 1'b0; cmdrd_q <= 1'b0; page_q <= '0; off_q <= '0;
        overrun <= 1'b0; underrun <= 1'b0; page_err <= 1'b0;
        soft_reset <= 1'b1;
        word_out   <= '0;
      end else begin
        if (do_rd) begin
          pend_q <= 1'b0;
          off_q  <= off_q + OFF_W'(1);
          if (!cmdrd_q) underrun <= 1'b1;
          if (page_ok) begin
            reg_rd     <= 1'b1;
            reg_page   <= page_q;
            reg_offset <= off_q;
          end else begin
            page_err <= 1'b1;
            word_out <= '1;
          end
        end
        if (do_wr) begin
          pend_q   <= 1'b0;
          word_out <= '0;
          if (!page_ok) page_err <= 1'b1;
          else if (!key_reg) begin
            reg_wr     <= 1'b1;
            reg_page   <= page_q;
            reg_offset <= off_q;
            reg_wdata  <= word_in;
          end
        end
        if (do_cmd) begin
          pend_q  <= 1'b1;
          cmdrd_q <= word_in[DIR_BIT];
          page_q  <= word_in[PG_TOP -: PAGE_W];
          off_q   <= word_in[OFF_TOP -: OFF_W];
          if (pend_q && cmdrd_q) overrun <= 1'b1;
          if (!do_rd) word_out <= '0;
        end
        if (word_valid && !acc) word_out <= '0;
      end
    end
  end

  p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !acc) |=> (word_out == '0 && !reg_wr && !reg_rd));

  p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_rd_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rd) |-> $past(word_valid));

  p_page_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> (reg_page < PAGE_W'(NUM_PAGES)));

  p_key_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |-> (!overrun && !underrun && !page_err && !reg_wr));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !key_hit) |=> overrun);

  p_sticky_udr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !key_hit) |=> underrun);
endmodule

// File: tb/spi_page_front_test.sv
`timescale 1ns/1ps
module spi_page_front_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [15:0] word_in = '0;
  logic [4:0]  word_len = 5'd16;
  logic [15:0] word_out, reg_wdata, reg_rdata;
  logic [3:0]  reg_page;
  logic [5:0]  reg_offset;
  logic reg_wr, reg_rd, soft_reset, overrun, underrun, page_err;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] model_data(input logic [3:0] p, input logic [5:0] o);
    return {2'b10, p, o, 4'h5};
  endfunction

  assign reg_rdata = model_data(reg_page, reg_offset);

  spi_page_front uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
    .word_len(word_len), .word_out(word_out), .reg_page(reg_page),
    .reg_offset(reg_offset), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .soft_reset(soft_reset),
    .overrun(overrun), .underrun(underrun), .page_err(page_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hard_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Drives one word; returns at the negedge after the capturing edge.
  task automatic send(input logic [15:0] w, input logic [4:0] len = 5'd16);
    @(negedge clk);
    word_valid = 1'b1; word_in = w; word_len = len;
    @(negedge clk);
    word_valid = 1'b0; word_in = '0; word_len = 5'd16;
  endtask

  task automatic gap();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    hard_reset();
    chk("R11 outputs", {word_out, reg_wr, reg_rd, soft_reset, overrun, underrun, page_err, reg_page, reg_offset}, '0);
  endtask

  task automatic t_write();
    hard_reset();
    send(16'h0860);
    chk("R2 command no strobe", {reg_wr, reg_rd}, 2'b00);
    gap();
    send(16'h1234);
    chk("R3 write strobe", {reg_wr, reg_page, reg_offset, reg_wdata}, {1'b1, 4'd1, 6'd3, 16'h1234});
    @(negedge clk);
    chk("R3 single pulse", reg_wr, 1'b0);
    gap();
    send(16'h10E0);
    gap();
    send(16'h0000);
    chk("R3 zero data write", {reg_wr, reg_rd, reg_page, reg_offset, reg_wdata}, {2'b10, 4'd2, 6'd7, 16'h0000});
    chk("R6 no underrun on write data", underrun, 1'b0);
  endtask

  task automatic t_read();
    hard_reset();
    send(16'h9140);
    gap();
    send(16'h0000);
    chk("R4 read strobe", {reg_rd, reg_page, reg_offset}, {1'b1, 4'd2, 6'd10});
    @(negedge clk);
    chk("R4 word_out", word_out, model_data(4'd2, 6'd10));
    gap();
    send(16'h0000);
    chk("R5 next offset", {reg_rd, reg_offset}, {1'b1, 6'd11});
    @(negedge clk);
    chk("R5 word_out next", word_out, model_data(4'd2, 6'd11));
    chk("R6 sequential no underrun", underrun, 1'b0);
    gap();
    send(16'h87E0);
    gap();
    send(16'h0000);
    chk("R5 offset 63", {reg_rd, reg_page, reg_offset}, {1'b1, 4'd0, 6'd63});
    gap();
    send(16'h0000);
    chk("R5 wrap to 0", {reg_rd, reg_offset}, {1'b1, 6'd0});
  endtask

  task automatic t_underrun();
    hard_reset();
    send(16'h0860);
    gap();
    send(16'h00AA);
    gap();
    send(16'h0000);
    chk("R6 idle zero reads same offset", {reg_rd, reg_page, reg_offset}, {1'b1, 4'd1, 6'd3});
    chk("R6 underrun set", underrun, 1'b1);
    gap();
    send(16'h0000);
    chk("R10 underrun held", {underrun, reg_offset}, {1'b1, 6'd4});
  endtask

  task automatic t_overrun();
    hard_reset();
    send(16'h8840);
    gap();
    send(16'h9140);
    chk("R7 read at old address", {reg_rd, reg_page, reg_offset}, {1'b1, 4'd1, 6'd2});
    chk("R7 overrun", overrun, 1'b1);
    gap();
    send(16'h0000);
    chk("R7 new command used", {reg_rd, reg_page, reg_offset}, {1'b1, 4'd2, 6'd10});
    chk("R10 overrun held", overrun, 1'b1);
  endtask

  task automatic t_badpage();
    hard_reset();
    send(16'h2820);
    gap();
    send(16'h0055);
    chk("R8 bad page write", {reg_wr, reg_rd, page_err}, 3'b001);
    gap();
    send(16'hB800);
    gap();
    send(16'h0000);
    chk("R8 bad page read no strobe", reg_rd, 1'b0);
    chk("R8 bad page read word", word_out, 16'hFFFF);
  endtask

  task automatic t_width();
    hard_reset();
    send(16'h9140);
    gap();
    send(16'h0000);
    @(negedge clk);
    chk("R4 word_out before reject", word_out, model_data(4'd2, 6'd10));
    gap();
    send(16'h0860, 5'd12);
    chk("R1 reject zeroes word_out", {word_out, reg_wr, reg_rd}, {16'h0000, 2'b00});
    gap();
    send(16'h0860, 5'd8);
    gap();
    send(16'h1234);
    chk("R1 rejected word not a command", {reg_wr, reg_rd}, 2'b00);
    gap();
    send(16'h00C3);
    chk("R1 state intact", {reg_wr, reg_page, reg_offset, reg_wdata}, {1'b1, 4'd2, 6'd17, 16'h00C3});
  endtask

  task automatic t_key();
    hard_reset();
    send(16'h0860); gap(); send(16'h0001); gap();
    send(16'h0000);
    chk("R6 underrun before key", underrun, 1'b1);
    gap();
    send(16'h0880); gap();
    send(16'h1234);
    chk("R9 wrong key ignored", {reg_wr, soft_reset, underrun}, 3'b001);
    gap();
    send(16'h0880); gap();
    send(16'hBB00);
    chk("R9 key pulse", {reg_wr, soft_reset, underrun, overrun, page_err}, 5'b01000);
    @(negedge clk);
    chk("R9 pulse single", soft_reset, 1'b0);
    gap();
    send(16'h0000);
    chk("R9 state cleared", {reg_rd, reg_page, reg_offset, underrun}, {1'b1, 4'd0, 6'd0, 1'b1});
  endtask

  initial begin
    #400us;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_write();
    t_read();
    t_underrun();
    t_overrun();
    t_badpage();
    t_width();
    t_key();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule